// File: doc/BRIEF.md
# Audio sampling rate classifier

This block tells which standard audio sampling rate a frame clock is running at. One of eight frame-clock inputs is picked by a source select: receiver output, converter output, three auxiliary inputs, main output port, auxiliary output port, and transmitter input, as indices 0 to 7. The block counts cycles of its 24.576 MHz reference clock across a fixed number of frame periods of that input. It then maps the count onto one of fifteen standard rates. A rate counts as a match only if it falls within ±2% of the nominal value. A rate that matches none of them, and a source that stops toggling, both give the out-of-range code.

The result appears as one status byte. The byte holds the rate code, the index of the source that was measured, and a done flag. Writing a new source select, or pulsing start, throws away the current result and begins a new measurement. There is no data stream in this block. The select, the start strobe and the status byte are plain level-type control and status pins, with no valid/ready handshake.

Top module: `fs_classifier`

## Requirements
- R1: While reset is held with a select of 0, the status byte reads 0x00.
- R2: The status byte is laid out as follows. Bits [3:0] hold the rate code. Bits [6:4] hold the currently selected source index. Bit 7 is the done flag.
- R3: A frame clock at a nominal rate gives this code. 8 kHz gives 1, 11.025 kHz gives 2, 12 kHz gives 3, 16 kHz gives 4, 22.05 kHz gives 5, 24 kHz gives 6, 32 kHz gives 7, 44.1 kHz gives 8, 48 kHz gives 9, 64 kHz gives 10, 88.2 kHz gives 11, 96 kHz gives 12, 128 kHz gives 13, 176.4 kHz gives 14 and 192 kHz gives 15. The done flag is set along with the code.
- R4: The acceptance window for each nominal rate runs from 98% to 102% of that rate, both ends included. For a frame period of P reference cycles, a rate f is accepted when P·102·f ≥ 24 576 000·100 and P·98·f ≤ 24 576 000·100.
- R5: A frame rate that lies outside every window gives code 0 with done set.
- R6: Only the selected input affects the measurement. Activity on the other seven inputs is ignored.
- R7: A change of the source select clears done and the code at the next clock edge and restarts the measurement. The result that follows belongs to the new source.
- R8: A one-cycle pulse on start clears done and the code at the next clock edge, and a fresh result follows.
- R9: If the selected input shows no rising edge for longer than the 8 kHz window allows, the measurement ends with code 0 and done set.
- R10: Once done is set, the status byte holds steady until the next restart, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24.576 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 3 | Index of the frame clock to measure |
| frame_clk | input | 8 | Frame clocks of the eight sources, treated as asynchronous |
| start | input | 1 | One-cycle pulse that restarts the measurement |
| status | output | 8 | {done, source index, rate code} |

## Verification
The bench sweeps the nominal period of every standard rate and rotates the source index as it goes, so each code and each selector value appears in turn. Around 48 kHz and 192 kHz it walks every integer period across and just beyond the ±2% edges, and at 8 kHz it tries the two periods either side of each edge. These sweeps separate an inclusive window bound from an exclusive one and catch a swapped bound. A stuck input that is selected while the others toggle tells the timeout path apart from a leak between sources. Switching the select in the middle of a measurement, pulsing start after a result, and disturbing an unselected input while a result is held show that the restart and hold behaviour is correct.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NUM_RATES = 15;
  localparam int CODE_W    = 4;

  typedef enum logic [1:0] {ST_ARM, ST_MEAS, ST_HOLD} tmr_state_e;

  // Nominal rate in Hz for code idx+1, ascending.
  function automatic longint nominal_hz(input int idx);
    case (idx)
      0:  return 64'd8000;
      1:  return 64'd11025;
      2:  return 64'd12000;
      3:  return 64'd16000;
      4:  return 64'd22050;
      5:  return 64'd24000;
      6:  return 64'd32000;
      7:  return 64'd44100;
      8:  return 64'd48000;
      9:  return 64'd64000;
      10: return 64'd88200;
      11: return 64'd96000;
      12: return 64'd128000;
      13: return 64'd176400;
      default: return 64'd192000;
    endcase
  endfunction

  // Smallest accepted cycle count (rate at +2%).
  function automatic longint window_lo(input longint clk_hz, input int frames, input int idx);
    longint num, den;
    num = clk_hz * longint'(frames) * 64'd100;
    den = 64'd102 * nominal_hz(idx);
    return (num + den - 64'd1) / den;
  endfunction

  // Largest accepted cycle count (rate at -2%).
  function automatic longint window_hi(input longint clk_hz, input int frames, input int idx);
    longint num, den;
    num = clk_hz * longint'(frames) * 64'd100;
    den = 64'd98 * nominal_hz(idx);
    return num / den;
  endfunction
endpackage

// File: rtl/fsc_edge_sync.sv
module fsc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], raw_i};
  end

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];

  // A rising edge needs a low sample first, so two in a row cannot happen.
  assert_edge_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fsc_period_timer.sv
module fsc_period_timer #(
  parameter int WIN_FRAMES = 2,
  parameter int LIMIT      = 6268,
  parameter int CW         = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          rise_i,
  output logic          done_o,
  output logic          valid_o,
  output logic [CW-1:0] count_o
);
  localparam int            FW     = (WIN_FRAMES > 1) ? $clog2(WIN_FRAMES) : 1;
  localparam logic [FW-1:0] LAST_F = FW'(WIN_FRAMES - 1);
  localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);

  fsc_pkg::tmr_state_e st;
  logic [CW-1:0]       cnt;
  logic [FW-1:0]       frames;

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) begin
      st      <= fsc_pkg::ST_ARM;
      cnt     <= '0;
      frames  <= '0;
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      count_o <= '0;
    end else begin
      case (st)
        fsc_pkg::ST_ARM: begin
          if (rise_i) begin
            st     <= fsc_pkg::ST_MEAS;
            cnt    <= '0;
            frames <= '0;
          end else if (cnt == LIM_C) begin
            st     <= fsc_pkg::ST_HOLD;
            done_o <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        fsc_pkg::ST_MEAS: begin
          if (rise_i && frames == LAST_F) begin
            st      <= fsc_pkg::ST_HOLD;
            done_o  <= 1'b1;
            valid_o <= 1'b1;
            count_o <= cnt + 1'b1;
          end else if (cnt == LIM_C) begin
            st     <= fsc_pkg::ST_HOLD;
            done_o <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
            if (rise_i) frames <= frames + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM_C);

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !done_o && !valid_o);
endmodule

// File: rtl/fsc_rate_decoder.sv
module fsc_rate_decoder #(
  parameter int CLK_HZ     = 24576000,
  parameter int WIN_FRAMES = 2,
  parameter int CW         = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CW-1:0]               count_i,
  output logic [fsc_pkg::CODE_W-1:0]  code_o
);
  logic [fsc_pkg::NUM_RATES-1:0] hit;

  for (genvar i = 0; i < fsc_pkg::NUM_RATES; i++) begin : g_win
    localparam longint        LO   = fsc_pkg::window_lo(longint'(CLK_HZ), WIN_FRAMES, i);
    localparam longint        HI   = fsc_pkg::window_hi(longint'(CLK_HZ), WIN_FRAMES, i);
    localparam logic [CW-1:0] LO_C = CW'(LO);
    localparam logic [CW-1:0] HI_C = CW'(HI);
    assign hit[i] = (count_i >= LO_C) && (count_i <= HI_C);
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < fsc_pkg::NUM_RATES; i++)
      if (hit[i]) code_o = fsc_pkg::CODE_W'(i + 1);
  end

  // Windows of neighbouring rates never overlap.
  assert_single_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/fs_classifier.sv
module fs_classifier #(
  parameter int CLK_HZ      = 24576000,
  parameter int WIN_FRAMES  = 2,
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NUM_SRC)-1:0] src_sel,
  input  logic [NUM_SRC-1:0]         frame_clk,
  input  logic                       start,
  output logic [$clog2(NUM_SRC)+4:0] status
);
  localparam int SEL_W = $clog2(NUM_SRC);
  localparam int LIMIT = int'(fsc_pkg::window_hi(longint'(CLK_HZ), WIN_FRAMES, 0));
  localparam int CW    = $clog2(LIMIT + 2);

  logic [NUM_SRC-1:0]              rise_vec;
  logic [SEL_W-1:0]                sel_q;
  logic                            restart;
  logic                            done, valid;
  logic [CW-1:0]                   count;
  logic [fsc_pkg::CODE_W-1:0]      dec_code;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    fsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(frame_clk[s]), .rise_o(rise_vec[s]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= src_sel;
  end

  assign restart = start || (src_sel != sel_q);

  fsc_period_timer #(.WIN_FRAMES(WIN_FRAMES), .LIMIT(LIMIT), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .rise_i(rise_vec[sel_q]),
    .done_o(done), .valid_o(valid), .count_o(count));

  fsc_rate_decoder #(.CLK_HZ(CLK_HZ), .WIN_FRAMES(WIN_FRAMES), .CW(CW)) u_dec (
    .clk(clk), .rst_n(rst_n), .count_i(count), .code_o(dec_code));

  assign status = {done, sel_q, (done && valid) ? dec_code : {fsc_pkg::CODE_W{1'b0}}};

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !restart |=> done && $stable(status));
endmodule

// File: tb/test_fs_classifier.sv
`timescale 1ns/1ps
module test_fs_classifier;
  localparam longint REF = 24576000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] fclk = 8'd0;
  logic [7:0] status;

  int per [8];
  int errs = 0;
  int checks = 0;
  longint rates [15] = '{8000, 11025, 12000, 16000, 22050, 24000, 32000, 44100,
                         48000, 64000, 88200, 96000, 128000, 176400, 192000};

  always #2.5 clk = ~clk;

  fs_classifier i_fs_classifier (
    .clk(clk), .rst_n(rst_n), .src_sel(sel), .frame_clk(fclk),
    .start(start), .status(status));

  // Frame clock generator: period per[s] reference cycles, 0 = stuck low.
  initial begin
    int ph [8];
    int last [8];
    for (int s = 0; s < 8; s++) begin ph[s] = 0; last[s] = -1; end
    forever begin
      @(negedge clk);
      for (int s = 0; s < 8; s++) begin
        if (per[s] != last[s]) begin last[s] = per[s]; ph[s] = 0; end
        if (per[s] <= 0) fclk[s] = 1'b0;
        else begin
          fclk[s] = (ph[s] < per[s] / 2);
          ph[s] = (ph[s] + 1) % per[s];
        end
      end
    end
  end

  function automatic int exp_code(input int p);
    exp_code = 0;
    if (p <= 0) return 0;
    for (int i = 0; i < 15; i++)
      if (longint'(p) * 102 * rates[i] >= REF * 100 &&
          longint'(p) * 98 * rates[i] <= REF * 100) exp_code = i + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!status[7] && n < 20000) begin @(negedge clk); n++; end
    check(status[7] == 1'b1, req, status[7], 1);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Measure source s running at period p, check code and source field.
  task automatic run(input int s, input int p, input string req);
    per[s] = p;
    sel = 3'(s);
    @(negedge clk);
    pulse_start();
    wait_done(req);
    check(int'(status[3:0]) == exp_code(p), req, status[3:0], exp_code(p));
    check(int'(status[6:4]) == s, {req, "/R2 src"}, status[6:4], s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    logic [7:0] snap;
    per = '{3072, 2048, 1536, 1024, 768, 512, 384, 128};
    repeat (5) @(negedge clk);
    check(status == 8'h00, "R1 reset status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: every nominal rate, rotating sources
    for (int i = 0; i < 15; i++) begin
      int p;
      p = int'((REF + rates[i] / 2) / rates[i]);
      run(i % 8, p, "R3 nominal");
      check(int'(status[3:0]) == i + 1, "R3 code", status[3:0], i + 1);
    end

    // R4: window edges
    run(1, 3011, "R4 8k low-out");
    run(1, 3012, "R4 8k low-in");
    run(1, 3134, "R4 8k high-in");
    run(1, 3135, "R4 8k high-out");
    for (int p = 500; p <= 524; p++) run(2, p, "R4 48k sweep");
    for (int p = 122; p <= 134; p++) run(3, p, "R4 192k sweep");

    // R5: between windows
    run(4, 600, "R5 off-grid");
    check(status[3:0] == 4'd0, "R5 code zero", status[3:0], 0);

    // R6 / R9: selected source stuck, others toggling
    per[6] = 512;
    run(5, 0, "R9 stuck");
    check(status[3:0] == 4'd0, "R6 no leak from others", status[3:0], 0);

    // R7: select change mid-measurement
    per[6] = 1024;
    per[7] = 256;
    sel = 3'd6;
    @(negedge clk);
    pulse_start();
    repeat (100) @(negedge clk);
    sel = 3'd7;
    @(negedge clk);
    check(status[7] == 1'b0, "R7 done cleared", status[7], 0);
    check(status[6:4] == 3'd7, "R7 source field", status[6:4], 7);
    wait_done("R7 finish");
    check(status[3:0] == 4'd12, "R7 new source code", status[3:0], 12);

    // R8: start pulse after a result
    pulse_start();
    check(status[7] == 1'b0, "R8 done cleared", status[7], 0);
    check(status[3:0] == 4'd0, "R8 code cleared", status[3:0], 0);
    wait_done("R8 finish");
    check(status[3:0] == 4'd12, "R8 code again", status[3:0], 12);

    // R10: hold while others change
    snap = status;
    per[6] = 128;
    per[0] = 0;
    repeat (300) @(negedge clk);
    check(status == snap, "R10 hold", status, snap);

    report();
    $finish;
  end
endmodule